// File: doc/BRIEF.md
# Multi-channel down-counting timer

A timer peripheral with a small word-addressed register bus. It holds `NUM_CH` independent 32-bit down-counters. Each counter has a control word, an interval register and a readable current count. All channels share one interrupt-enable mask and one pending-status word. A single source-tick enable input drives every channel. Each channel divides that tick by a power of two, which software selects.

Software loads an interval. It then writes the control word with the enable and reload bits set, which copies the interval into the counter and starts it. In periodic mode the counter restarts from the interval each time it expires. In one-shot mode it expires once, and the hardware then clears the enable bit. Clearing enable does not stop the counter at once: it runs for a fixed number of further source ticks before it halts. Software must allow for this before it reprograms the channel. The clock-source field is kept only as stored configuration.

Top module: `tmr_multi_timer`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: The interrupt mask is at offset 0x00 and the pending word at 0x04. Bit n of each belongs to channel n. Channel n's control word is at 0x10·n+0x10, its interval at 0x10·n+0x14 and its count at 0x10·n+0x18. Any other offset reads 0, and writes to a count register are ignored.
- R3: Control bits are: bit 0 enable, bit 1 reload (a command that always reads back 0), bits 3:2 source select (stored only), bits 6:4 prescale, bit 7 one-shot.
- R4: A control write with reload set copies the interval into the count in the write cycle. If enable is set, counting starts with the next source tick.
- R5: A running channel decrements its count by one on every 2^prescale-th source tick, and on no other cycle.
- R6: A control write that sets enable on a channel whose enable was clear restarts that channel's prescale divider from zero.
- R7: On a counting tick where the count is already 0, the channel expires. Its pending bit is set, and in periodic mode (bit 7 = 0) the count reloads from the interval.
- R8: In one-shot mode (bit 7 = 1) an expiry sets the pending bit and clears enable, and the count then stays at 0.
- R9: After software clears enable, the channel keeps counting for exactly 2 more source ticks and then halts. Setting enable again during that window cancels the rest of it.
- R10: Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged. If an expiry and a clear of the same bit fall in one cycle, the bit ends set.
- R11: `irq` is high exactly when some channel has both its pending bit and its mask bit set. Writing the mask never changes the pending bits.
- R12: With an all-ones interval the count runs freely, so its bitwise inverse rises by one per counting tick. Writing the interval while the channel runs does not change the current count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | One-cycle source tick shared by all channels |
| bus_we | input | 1 | Write strobe, acts in the cycle it is high |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of pending bits that are unmasked |

## Verification
Two things can land on one pending bit in the same cycle: a channel's expiry setting it, and a software write clearing it. The bench provokes this by loading an interval of 3 with a tick on every cycle. It then places the clear write exactly on the fourth tick after the start, and requires the bit to read back as 1. A control write can also land on a counting tick, for example a reload or a disable that meets an expiry. Random traffic produces these collisions, and the bench judges each one against a cycle-level reference model in which the bus write always overrides the counter's own update.

// File: rtl/tmr_pkg.sv
// Package: shared constants and the control-word layout for the timer.
// Assumes the bus is word-addressed by byte offset and channel blocks use a fixed stride.
package tmr_pkg;
    localparam int CTRL_W   = 8;
    localparam int PRE_W    = 3;
    localparam int SRC_W    = 2;
    // The divider must count up to 2^(2^PRE_W - 1) - 1.
    localparam int DIV_W    = (1 << PRE_W) - 1;
    localparam int OFF_MASK = 'h00;
    localparam int OFF_PEND = 'h04;
    localparam int CH_BASE  = 'h10;
    localparam int CH_STRIDE = 'h10;
    localparam int SUB_CTRL = 'h0;
    localparam int SUB_IVAL = 'h4;
    localparam int SUB_CNT  = 'h8;
    localparam int B_EN      = 0;
    localparam int B_RELOAD  = 1;
    localparam int B_ONESHOT = 7;

    // Control word, with bit 7 as the MSB and bit 0 as the LSB.
    typedef struct packed {
        logic             oneshot;
        logic [PRE_W-1:0] pre;
        logic [SRC_W-1:0] src;
        logic             reload;
        logic             en;
    } ctrl_t;
endpackage

// File: rtl/tmr_channel.sv
// Module: one down-counting channel with its power-of-two divider and stop window.
// Assumes tick_en is a one-cycle pulse. A bus write in the same cycle as a counter
// update takes priority over that update.
module tmr_channel
    import tmr_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int DRAIN_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              ctrl_we,
    input  logic              ival_we,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl_q,
    output logic [DATA_W-1:0] ival_q,
    output logic [DATA_W-1:0] count_q,
    output logic              expire
);
    localparam int DRAIN_W = $clog2(DRAIN_TICKS + 1);

    ctrl_t              wr_ctrl;
    logic [DIV_W-1:0]   div_cnt;
    logic [DIV_W-1:0]   div_lim;
    logic [DRAIN_W-1:0] drain_cnt;
    logic               running;
    logic               step;

    assign wr_ctrl = ctrl_t'(wdata[CTRL_W-1:0]);

    // Purpose: derive the divider limit, the running state, the counting step and the expiry.
    always_comb begin
        div_lim = DIV_W'((32'd1 << ctrl_q.pre) - 32'd1);
        running = ctrl_q.en || (drain_cnt != '0);
        step    = tick_en && running && (div_cnt >= div_lim);
        expire  = step && (count_q == '0);
    end

    // Purpose: update the divider, the stop window, the count and the software-visible fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            ival_q    <= '0;
            count_q   <= '0;
            div_cnt   <= '0;
            drain_cnt <= '0;
        end else begin
            if (tick_en && running) begin
                div_cnt <= (div_cnt >= div_lim) ? '0 : div_cnt + 1'b1;
            end
            if (tick_en && !ctrl_q.en && (drain_cnt != '0)) begin
                drain_cnt <= drain_cnt - 1'b1;
            end
            if (step) begin
                if (count_q == '0) begin
                    if (ctrl_q.oneshot) begin
                        ctrl_q.en <= 1'b0;
                        drain_cnt <= '0;
                    end else begin
                        count_q <= ival_q;
                    end
                end else begin
                    count_q <= count_q - 1'b1;
                end
            end
            if (ival_we) begin
                ival_q <= wdata;
            end
            if (ctrl_we) begin
                ctrl_q        <= wr_ctrl;
                ctrl_q.reload <= 1'b0;
                if (wr_ctrl.en && !ctrl_q.en) begin
                    div_cnt   <= '0;
                    drain_cnt <= '0;
                end else if (!wr_ctrl.en && ctrl_q.en) begin
                    drain_cnt <= DRAIN_W'(DRAIN_TICKS);
                end
                if (wr_ctrl.reload) begin
                    count_q <= ival_q;
                end
            end
        end
    end
endmodule

// File: rtl/tmr_irq_ctrl.sv
// Module: shared interrupt mask and write-one-to-clear pending word.
// Assumes expire bits are one-cycle pulses. A set from an expiry beats a clear in the same cycle.
module tmr_irq_ctrl #(
    parameter int NUM_CH = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic              pend_we,
    input  logic [NUM_CH-1:0] wbits,
    input  logic [NUM_CH-1:0] expire,
    output logic [NUM_CH-1:0] mask_q,
    output logic [NUM_CH-1:0] pend_q,
    output logic              irq
);
    logic [NUM_CH-1:0] clr_bits;

    // Purpose: pick the bits that a pending-word write clears.
    always_comb clr_bits = pend_we ? wbits : '0;

    // Purpose: hold the mask and the pending flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            pend_q <= '0;
        end else begin
            if (mask_we) begin
                mask_q <= wbits;
            end
            pend_q <= (pend_q & ~clr_bits) | expire;
        end
    end

    // Purpose: combine the unmasked pending flags into one request line.
    always_comb irq = |(pend_q & mask_q);
endmodule

// File: rtl/tmr_multi_timer.sv
// Module: top of the multi-channel timer. It decodes the bus, holds one channel
// per NUM_CH, and provides the shared interrupt logic.
// Assumes single-cycle writes, combinational reads, and ADDR_W wide enough for all channel blocks.
module tmr_multi_timer
    import tmr_pkg::*;
#(
    parameter int NUM_CH      = 2,
    parameter int ADDR_W      = 8,
    parameter int DATA_W      = 32,
    parameter int DRAIN_TICKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'(OFF_MASK);
    localparam logic [ADDR_W-1:0] A_PEND = ADDR_W'(OFF_PEND);

    logic [NUM_CH-1:0]             ctrl_we_v;
    logic [NUM_CH-1:0]             ival_we_v;
    logic [NUM_CH-1:0]             expire_v;
    logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_v;
    logic [NUM_CH-1:0][DATA_W-1:0] ival_v;
    logic [NUM_CH-1:0][DATA_W-1:0] cnt_v;
    logic [NUM_CH-1:0]             mask_q;
    logic [NUM_CH-1:0]             pend_q;
    logic                          mask_we;
    logic                          pend_we;

    assign mask_we = bus_we && (bus_addr == A_MASK);
    assign pend_we = bus_we && (bus_addr == A_PEND);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_CTRL);
        localparam logic [ADDR_W-1:0] A_IVAL = ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_IVAL);
        ctrl_t ctrl_s;

        assign ctrl_we_v[i] = bus_we && (bus_addr == A_CTRL);
        assign ival_we_v[i] = bus_we && (bus_addr == A_IVAL);
        assign ctrl_v[i]    = ctrl_s;

        tmr_channel #(
            .DATA_W     (DATA_W),
            .DRAIN_TICKS(DRAIN_TICKS)
        ) u_channel (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick_en(tick_en),
            .ctrl_we(ctrl_we_v[i]),
            .ival_we(ival_we_v[i]),
            .wdata  (bus_wdata),
            .ctrl_q (ctrl_s),
            .ival_q (ival_v[i]),
            .count_q(cnt_v[i]),
            .expire (expire_v[i])
        );
    end

    tmr_irq_ctrl #(
        .NUM_CH(NUM_CH)
    ) u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .mask_we(mask_we),
        .pend_we(pend_we),
        .wbits  (bus_wdata[NUM_CH-1:0]),
        .expire (expire_v),
        .mask_q (mask_q),
        .pend_q (pend_q),
        .irq    (irq)
    );

    // Purpose: return the addressed register, or 0 for any unmapped offset.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_MASK) bus_rdata = DATA_W'(mask_q);
        if (bus_addr == A_PEND) bus_rdata = DATA_W'(pend_q);
        for (int i = 0; i < NUM_CH; i++) begin
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_CTRL)) bus_rdata = DATA_W'(ctrl_v[i]);
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_IVAL)) bus_rdata = ival_v[i];
            if (bus_addr == ADDR_W'(CH_BASE + CH_STRIDE * i + SUB_CNT))  bus_rdata = cnt_v[i];
        end
    end
endmodule

// File: rtl/tmr_multi_timer_chk.sv
// Module: property checker for the timer, bound to the top module.
// Assumes it is connected to the top-level decode and channel signals through the bind below.
module tmr_multi_timer_chk
    import tmr_pkg::*;
#(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          tick_en,
    input logic [ADDR_W-1:0]             bus_addr,
    input logic [DATA_W-1:0]             bus_rdata,
    input logic                          irq,
    input logic                          pend_we,
    input logic [NUM_CH-1:0]             ctrl_we_v,
    input logic [NUM_CH-1:0]             expire_v,
    input logic [NUM_CH-1:0]             pend_q,
    input logic [NUM_CH-1:0][CTRL_W-1:0] ctrl_v,
    input logic [NUM_CH-1:0][DATA_W-1:0] cnt_v
);
    // R10: with no pending-word write, a set pending bit stays set.
    p_pend_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pend_we |=> ((pend_q & $past(pend_q)) == $past(pend_q)));

    // R7: an expiry always leaves its pending bit set in the following cycle.
    p_expire_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (|expire_v) |=> ((pend_q & $past(expire_v)) == $past(expire_v)));

    // R5: without a source tick or a control write, no count moves.
    p_count_needs_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !(|ctrl_we_v)) |=> $stable(cnt_v));

    // R5: without a control write or an expiry, channel 0 either holds or steps down by one.
    p_step_by_one_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_we_v[0] && !expire_v[0]) |=>
            ((cnt_v[0] == $past(cnt_v[0])) || (cnt_v[0] == $past(cnt_v[0]) - 1'b1)));

    // R8: a one-shot expiry clears enable when no control write competes with it.
    p_oneshot_stops_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire_v[0] && ctrl_v[0][B_ONESHOT] && !ctrl_we_v[0]) |=> !ctrl_v[0][B_EN]);

    // R11: a request needs at least one pending bit.
    p_irq_needs_pend_r11: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|pend_q));

    // R2: an offset in the gap between the shared words and the channels reads 0.
    p_unmapped_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == ADDR_W'(8)) |-> (bus_rdata == '0));
endmodule

bind tmr_multi_timer tmr_multi_timer_chk #(
    .NUM_CH(NUM_CH),
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .bus_addr (bus_addr),
    .bus_rdata(bus_rdata),
    .irq      (irq),
    .pend_we  (pend_we),
    .ctrl_we_v(ctrl_we_v),
    .expire_v (expire_v),
    .pend_q   (pend_q),
    .ctrl_v   (ctrl_v),
    .cnt_v    (cnt_v)
);

// File: tb/test_tmr_multi_timer.sv
// Bench: directed corner cases plus seeded random traffic, checked against a cycle-level model.
module test_tmr_multi_timer;
    localparam int NCH = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    tmr_multi_timer i_tmr_multi_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model state, built from the requirements.
    logic        m_en[NCH], m_os[NCH];
    logic [2:0]  m_pre[NCH];
    logic [1:0]  m_src[NCH];
    logic [31:0] m_ival[NCH], m_cnt[NCH];
    int          m_pc[NCH], m_drain[NCH];
    logic [1:0]  m_pend, m_mask, exp_v;
    int          lim, wa;
    bit          run, stp, oen;
    logic [31:0] oival;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                m_en[c] = 0; m_os[c] = 0; m_pre[c] = 0; m_src[c] = 0;
                m_ival[c] = 0; m_cnt[c] = 0; m_pc[c] = 0; m_drain[c] = 0;
            end
            m_pend = 0; m_mask = 0;
        end else begin
            exp_v = 0;
            for (int c = 0; c < NCH; c++) begin
                wa   = 16 + 16 * c;
                oen  = m_en[c];
                oival = m_ival[c];
                run  = m_en[c] || (m_drain[c] != 0);
                lim  = (1 << m_pre[c]) - 1;
                stp  = tick_en && run && (m_pc[c] >= lim);
                if (tick_en && run) m_pc[c] = (m_pc[c] >= lim) ? 0 : m_pc[c] + 1;     // R5
                if (tick_en && !oen && m_drain[c] != 0) m_drain[c] = m_drain[c] - 1;  // R9
                if (stp) begin
                    if (m_cnt[c] == 0) begin
                        exp_v[c] = 1'b1;                                               // R7
                        if (m_os[c]) begin m_en[c] = 0; m_drain[c] = 0; end            // R8
                        else m_cnt[c] = m_ival[c];
                    end else m_cnt[c] = m_cnt[c] - 1;
                end
                if (bus_we && bus_addr == 8'(wa + 4)) m_ival[c] = bus_wdata;           // R12
                if (bus_we && bus_addr == 8'(wa)) begin                                // R3, R4, R6
                    if (bus_wdata[0] && !oen) begin m_pc[c] = 0; m_drain[c] = 0; end
                    else if (!bus_wdata[0] && oen) m_drain[c] = 2;
                    m_en[c]  = bus_wdata[0];
                    m_src[c] = bus_wdata[3:2];
                    m_pre[c] = bus_wdata[6:4];
                    m_os[c]  = bus_wdata[7];
                    if (bus_wdata[1]) m_cnt[c] = oival;
                end
            end
            if (bus_we && bus_addr == 8'h04) m_pend = m_pend & ~bus_wdata[1:0];        // R10
            m_pend = m_pend | exp_v;
            if (bus_we && bus_addr == 8'h00) m_mask = bus_wdata[1:0];                  // R11
        end
    end

    function automatic logic [31:0] exp_rd(input logic [7:0] a);
        logic [31:0] r = 0;
        if (a == 8'h00) r = 32'(m_mask);
        if (a == 8'h04) r = 32'(m_pend);
        for (int c = 0; c < NCH; c++) begin
            if (a == 8'(16 + 16 * c)) r = {24'd0, m_os[c], m_pre[c], m_src[c], 1'b0, m_en[c]};
            if (a == 8'(20 + 16 * c)) r = m_ival[c];
            if (a == 8'(24 + 16 * c)) r = m_cnt[c];
        end
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit t);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d; tick_en = t;
    endtask

    task automatic cyc(input bit t);
        @(negedge clk);
        bus_we = 1'b0; tick_en = t;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1);
    endtask

    // Read with an explicit expected value (masked) and a model comparison.
    task automatic rdx(input string tag, input logic [7:0] a, input logic [31:0] msk,
                       input logic [31:0] exp);
        logic [31:0] d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a; tick_en = 1'b0;
        #2 d = bus_rdata;
        chk(tag, d & msk, exp);
        chk({tag, " model"}, d, exp_rd(a));
    endtask

    task automatic rdm(input string tag, input logic [7:0] a, input bit t);
        logic [31:0] d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a; tick_en = t;
        #2 d = bus_rdata;
        chk(tag, d, exp_rd(a));
        chk({tag, " irq"}, 32'(irq), 32'(|(m_pend & m_mask)));
    endtask

    task automatic rdv(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a; tick_en = 1'b0;
        #2 d = bus_rdata;
    endtask

    initial begin
        #(20 * 200000);
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] c1, c2;
        void'($urandom(32'd1357));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: everything reads 0 after reset
        foreach (exp_v[i]) begin end
        rdx("R1 mask", 8'h00, '1, 0);
        rdx("R1 pend", 8'h04, '1, 0);
        for (int c = 0; c < NCH; c++) begin
            rdx("R1 ctrl", 8'(16 + 16 * c), '1, 0);
            rdx("R1 ival", 8'(20 + 16 * c), '1, 0);
            rdx("R1 count", 8'(24 + 16 * c), '1, 0);
        end
        chk("R1 irq", 32'(irq), 0);

        // R2: unmapped offsets read 0; count writes ignored
        wr(8'h08, 32'hDEAD_BEEF, 0);
        rdx("R2 gap 0x08", 8'h08, '1, 0);
        rdx("R2 gap 0x1C", 8'h1C, '1, 0);
        rdx("R2 beyond 0x30", 8'h30, '1, 0);
        wr(8'h18, 32'h1234_5678, 0);
        rdx("R2 count write ignored", 8'h18, '1, 0);

        // R3: control readback drops the reload command bit
        wr(8'h20, 32'hFE, 0);
        rdx("R3 ctrl fields", 8'h20, '1, 32'hFC);
        wr(8'h20, 32'h00, 0);

        // R4, R5, R7: periodic channel 0, interval 10, prescale 1
        wr(8'h14, 10, 0);
        wr(8'h10, 32'h03, 0);
        rdx("R4 load on start", 8'h18, '1, 10);
        ticks(3);
        rdx("R5 three ticks", 8'h18, '1, 7);
        ticks(7);
        rdx("R5 reached zero", 8'h18, '1, 0);
        rdx("R7 no early pending", 8'h04, 32'h1, 0);
        ticks(1);
        rdx("R7 reload after expiry", 8'h18, '1, 10);
        rdx("R7 pending set", 8'h04, 32'h1, 1);

        // R11: irq follows the mask
        chk("R11 masked irq low", 32'(irq), 0);
        wr(8'h00, 1, 0);
        cyc(0);
        chk("R11 unmasked irq high", 32'(irq), 1);
        rdx("R11 mask write leaves pending", 8'h04, 32'h1, 1);
        wr(8'h00, 2, 0);
        cyc(0);
        chk("R11 other mask irq low", 32'(irq), 0);

        // R10: write-one-to-clear
        wr(8'h04, 0, 0);
        rdx("R10 zero write no effect", 8'h04, 32'h1, 1);
        wr(8'h04, 1, 0);
        rdx("R10 one clears", 8'h04, 32'h1, 0);

        // R9: disable drains exactly 2 ticks
        wr(8'h10, 32'h00, 0);
        ticks(5);
        rdx("R9 two tick drain", 8'h18, '1, 8);

        // R6: re-enable with prescale 4 restarts the divider
        wr(8'h10, 32'h21, 0);
        ticks(3);
        rdx("R6 no step before 4 ticks", 8'h18, '1, 8);
        ticks(1);
        rdx("R6 R5 step on 4th tick", 8'h18, '1, 7);

        // R8: one-shot on channel 1, interval 2
        wr(8'h24, 2, 0);
        wr(8'h20, 32'h83, 0);
        ticks(2);
        rdx("R8 count at zero", 8'h28, '1, 0);
        rdx("R8 not yet pending", 8'h04, 32'h2, 0);
        ticks(1);
        rdx("R8 enable cleared", 8'h20, '1, 32'h80);
        rdx("R8 pending set", 8'h04, 32'h2, 2);
        ticks(3);
        rdx("R8 stays at zero", 8'h28, '1, 0);

        // R10: expiry and clear in the same cycle, set wins
        wr(8'h04, 3, 0);
        wr(8'h24, 3, 0);
        wr(8'h20, 32'h03, 0);
        cyc(1); cyc(1); cyc(1);
        wr(8'h04, 2, 1);
        rdx("R10 set beats clear", 8'h04, 32'h2, 2);

        // R12: free-running all-ones interval; interval write mid-run
        wr(8'h24, 32'hFFFF_FFFF, 0);
        wr(8'h20, 32'h03, 0);
        rdv(8'h28, c1);
        ticks(5);
        wr(8'h24, 5, 1);
        rdv(8'h28, c2);
        chk("R12 inverse count rises by ticks", ~c2 - ~c1, 6);
        rdx("R12 count undisturbed", 8'h28, '1, 32'hFFFF_FFF9);

        // Random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            int sel;
            logic [7:0] a;
            logic [31:0] d;
            sel = $urandom % 8;
            case (sel)
                0: a = 8'h00;
                1: a = 8'h04;
                2: a = 8'h10;
                3: a = 8'h14;
                4: a = 8'h20;
                5: a = 8'h24;
                6: a = 8'h18;
                default: a = 8'h0C;
            endcase
            d = (a == 8'h14 || a == 8'h24) ? ($urandom % 8) : $urandom;
            if (a == 8'h10 || a == 8'h20) d = d & 32'h9F;
            if ($urandom % 3 == 0) wr(a, d, 1'($urandom % 2));
            else cyc(1'($urandom % 2));
            rdm("R2 R5 R7 R9 R10 random", 8'(16 + 8 + 16 * ($urandom % 2)), 1'($urandom % 2));
            if (i % 16 == 0) rdm("R10 R11 random pend", 8'h04, 1'b1);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule